// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns activity on eight GPIO pins into a single interrupt request. It does not sample the pads itself. The pin-capture logic beside it supplies three vectors:

- the synchronized input values;
- the direction vector, where a 1 marks a pin driven as an output;
- a one-cycle strobe per bit, set in the cycle a captured input bit takes a new value.

Each pin can be set up in one of two ways. As a level detector, it watches for a chosen high or low level. As an edge detector, it watches for a rising edge, a falling edge, or either edge.

Detected events accumulate in a sticky raw status vector. An enable vector selects which status bits reach the interrupt line. Software reads the raw and the enabled status at fixed offsets. It acknowledges events by writing ones to a clear offset.

The register decode covers only the offsets that belong to this block. Configuration writes take effect from the next clock. Reads are combinational from the current register contents.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every configuration register and the raw status read 0, and `irq` is low.
- R2: Four configuration registers are written and read back at their own offsets, 8 bits wide. Bit i of each register applies to pin i:
  - offset 0x404 holds the sense selection: 1 means level, 0 means edge;
  - offset 0x408 holds the both-edge selection;
  - offset 0x40C holds the polarity: 1 means high or rising, 0 means low or falling;
  - offset 0x410 holds the interrupt enable.
- R3: For an edge-sensed pin with both-edge off, the raw status bit is set on the clock where the pin is an input (direction 0), its change strobe is 1, and its new value equals its polarity bit.
- R4: For an edge-sensed pin with both-edge set, any strobed change on an input pin sets the status bit, whatever its polarity bit holds.
- R5: An edge-sensed pin sets no status without a change strobe, and never while its direction bit is 1.
- R6: A level-sensed pin sets its status bit on every clock where its value equals its polarity bit. It sets the bit again on the clock after a clear for as long as the level holds.
- R7: A write to offset 0x41C clears each raw status bit whose written bit is 1. Bits written as 0 are unchanged.
- R8: When a clear and a new event hit the same bit on the same clock, the bit stays set.
- R9: Offset 0x414 reads the raw status, offset 0x418 reads raw status AND enable, and any other offset reads 0.
- R10: `irq` is high exactly when raw status AND enable is nonzero.
- R11: Writes to offsets 0x414 and 0x418 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_val | input | 8 | Synchronized pin input values |
| pin_dir | input | 8 | Direction per pin, 1 = output |
| pin_chg | input | 8 | Per-bit strobe: input bit changed this cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The main sweep draws several hundred pseudo-random combinations of the inputs below:

- sense, both-edge and polarity settings;
- direction, pin value and change strobe.

For each combination it predicts every status bit from the rules. That separates level from edge behaviour, rising from falling edges, both-edge from single-edge mode, and strobed from unstrobed pins, all in one vector.

Each combination is then held idle and cleared. This shows that edge bits stay sticky while level bits come back immediately.

Directed cases cover the remaining rules:

- a clear that lands on the same clock as an event;
- a partial clear;
- writes aimed at the read-only offsets;
- read-back of each configuration register.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 8,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  pin_val,
  input  logic [W-1:0]  pin_dir,
  input  logic [W-1:0]  pin_chg,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_SENSE = AW'('h404);
  localparam logic [AW-1:0] A_BOTH  = AW'('h408);
  localparam logic [AW-1:0] A_POL   = AW'('h40C);
  localparam logic [AW-1:0] A_EN    = AW'('h410);
  localparam logic [AW-1:0] A_RAW   = AW'('h414);
  localparam logic [AW-1:0] A_MSK   = AW'('h418);
  localparam logic [AW-1:0] A_CLR   = AW'('h41C);

  logic [W-1:0] cfg_level, cfg_both, cfg_pol, cfg_en, stat_q;
  logic [W-1:0] match, edge_hit, lvl_hit, clr;

  assign match    = ~(pin_val ^ cfg_pol);
  assign edge_hit = pin_chg & ~pin_dir & ~cfg_level & (cfg_both | match);
  assign lvl_hit  = cfg_level & match;
  assign clr      = (bus_wr && bus_addr == A_CLR) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_level <= '0;
      cfg_both  <= '0;
      cfg_pol   <= '0;
      cfg_en    <= '0;
      stat_q    <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_SENSE: cfg_level <= bus_wdata;
          A_BOTH:  cfg_both  <= bus_wdata;
          A_POL:   cfg_pol   <= bus_wdata;
          A_EN:    cfg_en    <= bus_wdata;
          default: ;
        endcase
      end
      stat_q <= (stat_q & ~clr) | edge_hit | lvl_hit;
    end
  end

  always_comb begin
    case (bus_addr)
      A_SENSE: bus_rdata = cfg_level;
      A_BOTH:  bus_rdata = cfg_both;
      A_POL:   bus_rdata = cfg_pol;
      A_EN:    bus_rdata = cfg_en;
      A_RAW:   bus_rdata = stat_q;
      A_MSK:   bus_rdata = stat_q & cfg_en;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = |(stat_q & cfg_en);
endmodule

module gpio_irq_detect_chk #(
  parameter int W = 8,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  pin_val,
  input logic [W-1:0]  pin_dir,
  input logic [W-1:0]  pin_chg,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic          irq,
  input logic [W-1:0]  level_r,
  input logic [W-1:0]  both_r,
  input logic [W-1:0]  pol_r,
  input logic [W-1:0]  en_r,
  input logic [W-1:0]  raw_r
);
  logic [W-1:0] want;
  always_comb begin
    for (int i = 0; i < W; i++) begin
      if (level_r[i])                      want[i] = (pin_val[i] == pol_r[i]);
      else if (pin_chg[i] && !pin_dir[i])  want[i] = both_r[i] || (pin_val[i] == pol_r[i]);
      else                                 want[i] = 1'b0;
    end
  end

  assert_event_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (want != '0) |=> ((raw_r & $past(want)) == $past(want)));

  assert_no_spurious_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_r & ~$past(raw_r) & ~$past(want)) == '0));

  assert_only_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == AW'('h41C)) |=> ((~raw_r & $past(raw_r)) == '0));

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(level_r) && $stable(both_r) && $stable(pol_r) && $stable(en_r)));

  assert_irq_off_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_r == '0) |-> !irq);
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.W(W), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .pin_val(pin_val), .pin_dir(pin_dir), .pin_chg(pin_chg),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq),
  .level_r(cfg_level), .both_r(cfg_both), .pol_r(cfg_pol), .en_r(cfg_en), .raw_r(stat_q)
);

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] pin_val = '0, pin_dir = '0, pin_chg = '0, bus_wdata = '0;
  logic bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0] bus_rdata;
  logic irq;
  int vec = 0, bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  gpio_irq_detect uut (.clk(clk), .rst_n(rst_n), .pin_val(pin_val), .pin_dir(pin_dir),
    .pin_chg(pin_chg), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  function automatic logic [7:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  function automatic logic [7:0] predict(logic [7:0] sn, logic [7:0] bo, logic [7:0] pl,
                                         logic [7:0] dr, logic [7:0] v, logic [7:0] ch);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      if (sn[i]) r[i] = (v[i] == pl[i]);
      else if (ch[i] && !dr[i]) r[i] = bo[i] ? 1'b1 : (v[i] == pl[i]);
    end
    return r;
  endfunction

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [7:0] sn, bo, pl, en, dr, v, ch, exp, lvl;
    #23 rst_n = 1'b1;
    tick();
    // R1 reset values
    foreach (sn[i]) begin end
    bus_addr = 12'h404; #1 chk("R1 sense", bus_rdata, 8'h00);
    bus_addr = 12'h408; #1 chk("R1 both", bus_rdata, 8'h00);
    bus_addr = 12'h40C; #1 chk("R1 pol", bus_rdata, 8'h00);
    bus_addr = 12'h410; #1 chk("R1 en", bus_rdata, 8'h00);
    bus_addr = 12'h414; #1 chk("R1 raw", bus_rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R2 read-back
    wr(12'h408, 8'hA5); wr(12'h40C, 8'h3C); wr(12'h410, 8'h96); wr(12'h404, 8'h00);
    bus_addr = 12'h408; #1 chk("R2 both", bus_rdata, 8'hA5);
    bus_addr = 12'h40C; #1 chk("R2 pol", bus_rdata, 8'h3C);
    bus_addr = 12'h410; #1 chk("R2 en", bus_rdata, 8'h96);
    bus_addr = 12'h420; #1 chk("R9 unmapped", bus_rdata, 8'h00);

    // Sweep: R3 R4 R5 R6 R7 R9 R10
    for (int t = 0; t < 400; t++) begin
      sn = rnd(); bo = rnd(); pl = rnd(); en = rnd(); dr = rnd(); v = rnd(); ch = rnd();
      pin_chg = '0; pin_val = v; pin_dir = dr;
      wr(12'h404, 8'h00); wr(12'h408, bo); wr(12'h40C, pl); wr(12'h410, en);
      wr(12'h41C, 8'hFF); wr(12'h404, sn);
      bus_addr = 12'h414; #1 chk("R7 cleared", bus_rdata, 8'h00);
      pin_chg = ch;
      tick();
      pin_chg = '0;
      exp = predict(sn, bo, pl, dr, v, ch);
      lvl = sn & ~(v ^ pl);
      bus_addr = 12'h414; #1 chk("R3 R4 R6 raw", bus_rdata, exp);
      bus_addr = 12'h418; #1 chk("R9 masked", bus_rdata, exp & en);
      chk("R10 irq", {7'b0, irq}, {7'b0, |(exp & en)});
      tick();
      bus_addr = 12'h414; #1 chk("R5 sticky idle", bus_rdata, exp);
      wr(12'h41C, 8'hFF);
      bus_addr = 12'h414; #1 chk("R6 level reasserts", bus_rdata, lvl);
    end

    // R8 clear and event same cycle
    pin_dir = '0; pin_val = 8'h01;
    wr(12'h404, 8'h00); wr(12'h408, 8'h01); wr(12'h410, 8'hFF); wr(12'h41C, 8'hFF);
    pin_chg = 8'h01; pin_val = 8'h00;
    wr(12'h41C, 8'hFF);
    pin_chg = '0;
    bus_addr = 12'h414; #1 chk("R8 event wins", bus_rdata, 8'h01);

    // R7 partial clear
    wr(12'h40C, 8'hFF);
    pin_val = 8'hF0; pin_chg = 8'hF0;
    tick(); pin_chg = '0;
    wr(12'h41C, 8'h30);
    bus_addr = 12'h414; #1 chk("R7 partial clear", bus_rdata, 8'hC1);

    // R11 writes to read-only offsets
    wr(12'h414, 8'h00); wr(12'h418, 8'h00);
    bus_addr = 12'h414; #1 chk("R11 raw kept", bus_rdata, 8'hC1);
    bus_addr = 12'h410; #1 chk("R11 en kept", bus_rdata, 8'hFF);
    bus_addr = 12'h404; #1 chk("R11 sense kept", bus_rdata, 8'h00);
    chk("R10 irq high", {7'b0, irq}, 8'h01);
    wr(12'h410, 8'h00);
    chk("R10 irq disabled", {7'b0, irq}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule